// File: doc/BRIEF.md
# Deserializer Sampling-Phase Centring Engine

This engine moves the sampling phase of a deserializer into the middle of the valid eye of a recovered link clock. Each cycle it looks at the 7-bit word sampled from the clock lane. It steers an external phase-shifting clock source through a request/acknowledge handshake, one step at a time, in a chosen direction. A one-cycle `start` pulse while idle launches a run. The run ends with a one-cycle `done` pulse, and `success` is valid in that same cycle.

A phase position is judged good only when a long unbroken run of matching words is seen, so an edge that jitters does not count as good. The run has four stages:
1. Step forward out of whatever window the phase is in now, then step once more.
2. Step forward until a stable window begins, giving up after a bounded number of fruitless steps.
3. Walk across the window and count its width.
4. Step back by half that width.

The clock-lane sample is a free-running word with no handshake. The only transaction at the block's edge is the shift handshake. The block never raises a new request until the previous one has been acknowledged, so the external shifter may take as long as it needs.

Top module: `phase_eye_centerer`

## Requirements
- R1: A sample word counts as a match only when it equals 7'b1100011 (bit 6 first). Any other value, including one that differs in a single bit, counts as a miss.
- R2: A position is judged good only after 128 consecutive matching words. One miss ends that evaluation immediately with a bad verdict.
- R3: A run first steps forward while the current position is judged good. It then issues exactly one extra forward step, whatever the verdict.
- R4: While searching for a window, every bad verdict is followed by one forward step, and the steps are counted. When the count exceeds 1024, the run ends with `success`=0. A window reached after exactly 1024 search steps is accepted.
- R5: The width of the found window starts at 1. One forward step is taken, and each further good verdict adds one step and one unit of width, until a bad verdict ends the walk. The width counter saturates instead of wrapping.
- R6: After the walk, exactly width/2 (integer division) backward steps are issued and the run ends with `success`=1. A window of width 1 gives no backward step.
- R7: `shift_dir`=1 means a forward step and 0 means a backward step. `shift_req` is a single-cycle pulse.
- R8: After a request, no new request is issued until `shift_ack` has returned for it.
- R9: `done` is high for exactly one cycle, when `active` falls. `success` holds its value until the next `start`.
- R10: After reset `active`, `done`, `success` and `shift_req` are low, and no request appears while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a run when idle; ignored while active |
| sample | input | 7 | Clock-lane word from the deserializer |
| shift_ack | input | 1 | One-cycle completion of the outstanding phase step |
| shift_req | output | 1 | One-cycle phase step request |
| shift_dir | output | 1 | Step direction: 1 forward, 0 backward |
| active | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| success | output | 1 | Result of the last run, valid with `done` |

## Verification
The properties assume that the external shifter acknowledges each request exactly once and never acknowledges when nothing is outstanding. They also assume that `start` matters only while the block is idle. The bench's shifter model answers every request with a single acknowledge two cycles later and moves its phase position at that moment. Its eye model is periodic and can mark jittery positions, which glitch every 32 cycles, and near-miss words, so that the filter, the search bound and the centring are all exercised within these assumptions.

// File: rtl/phalign_pkg.sv
package phalign_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LEAVE_CHK,
    ST_LEAVE_SH,
    ST_SKIP_SH,
    ST_SEEK_CHK,
    ST_SEEK_SH,
    ST_MEAS_SH,
    ST_MEAS_CHK,
    ST_BACK_SH
  } eng_state_t;
endpackage

// File: rtl/phalign_filter.sv
module phalign_filter #(
  parameter int SAMPLE_W = 7,
  parameter logic [SAMPLE_W-1:0] GOOD_WORD = 7'b1100011,
  parameter int FILT_LEN = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                res_vld,
  output logic                res_pass
);
  localparam int RUN_W = $clog2(FILT_LEN) + 1;

  logic             run;
  logic [RUN_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      run_cnt  <= '0;
      res_vld  <= 1'b0;
      res_pass <= 1'b0;
    end else begin
      res_vld <= 1'b0;
      if (go) begin
        run     <= 1'b1;
        run_cnt <= '0;
      end else if (run) begin
        if (sample != GOOD_WORD) begin
          run      <= 1'b0;
          res_vld  <= 1'b1;
          res_pass <= 1'b0;
        end else if (run_cnt == RUN_W'(FILT_LEN - 1)) begin
          run      <= 1'b0;
          res_vld  <= 1'b1;
          res_pass <= 1'b1;
        end else begin
          run_cnt <= run_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/phalign_shift.sv
module phalign_shift (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic dir_in,
  input  logic ack,
  output logic req,
  output logic dir,
  output logic fin
);
  logic pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req  <= 1'b0;
      dir  <= 1'b0;
      pend <= 1'b0;
      fin  <= 1'b0;
    end else begin
      req <= 1'b0;
      fin <= 1'b0;
      if (go) begin
        req  <= 1'b1;
        dir  <= dir_in;
        pend <= 1'b1;
      end else if (pend && ack) begin
        pend <= 1'b0;
        fin  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/phalign_satcnt.sv
module phalign_satcnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                 q <= '0;
    else if (clr)               q <= '0;
    else if (inc && (q != '1))  q <= q + 1'b1;
  end
endmodule

// File: rtl/phase_eye_centerer.sv
module phase_eye_centerer #(
  parameter int SAMPLE_W = 7,
  parameter logic [SAMPLE_W-1:0] GOOD_WORD = 7'b1100011,
  parameter int FILT_LEN = 128,
  parameter int MAX_SEEK = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                shift_ack,
  output logic                shift_req,
  output logic                shift_dir,
  output logic                active,
  output logic                done,
  output logic                success
);
  import phalign_pkg::*;

  localparam int CNT_W = $clog2(MAX_SEEK) + 2;
  localparam int HALF_W = CNT_W + 1;

  eng_state_t st;
  logic chk_go, sh_go, sh_dir_go;
  logic res_vld, res_pass, sh_fin;
  logic seek_clr, seek_inc, wid_clr, wid_inc;
  logic [CNT_W-1:0]  seek_q, wid_q;
  logic [HALF_W-1:0] half_w, bk;

  phalign_filter #(
    .SAMPLE_W (SAMPLE_W),
    .GOOD_WORD(GOOD_WORD),
    .FILT_LEN (FILT_LEN)
  ) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (chk_go),
    .sample  (sample),
    .res_vld (res_vld),
    .res_pass(res_pass)
  );

  phalign_shift u_sh (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (sh_go),
    .dir_in(sh_dir_go),
    .ack   (shift_ack),
    .req   (shift_req),
    .dir   (shift_dir),
    .fin   (sh_fin)
  );

  phalign_satcnt #(.W(CNT_W)) u_seek (
    .clk(clk), .rst_n(rst_n), .clr(seek_clr), .inc(seek_inc), .q(seek_q)
  );

  phalign_satcnt #(.W(CNT_W)) u_wid (
    .clk(clk), .rst_n(rst_n), .clr(wid_clr), .inc(wid_inc), .q(wid_q)
  );

  always_comb begin
    seek_clr = (st == ST_SKIP_SH) && sh_fin;
    seek_inc = (st == ST_SEEK_CHK) && res_vld && !res_pass;
    wid_clr  = (st == ST_SEEK_CHK) && res_vld && res_pass;
    wid_inc  = (st == ST_MEAS_CHK) && res_vld && res_pass;
    half_w   = (HALF_W'(wid_q) + 1'b1) >> 1;
  end

  assign active = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      chk_go    <= 1'b0;
      sh_go     <= 1'b0;
      sh_dir_go <= 1'b0;
      bk        <= '0;
      done      <= 1'b0;
      success   <= 1'b0;
    end else begin
      chk_go <= 1'b0;
      sh_go  <= 1'b0;
      done   <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          success <= 1'b0;
          chk_go  <= 1'b1;
          st      <= ST_LEAVE_CHK;
        end
        ST_LEAVE_CHK: if (res_vld) begin
          sh_go     <= 1'b1;
          sh_dir_go <= 1'b1;
          st        <= res_pass ? ST_LEAVE_SH : ST_SKIP_SH;
        end
        ST_LEAVE_SH: if (sh_fin) begin
          chk_go <= 1'b1;
          st     <= ST_LEAVE_CHK;
        end
        ST_SKIP_SH: if (sh_fin) begin
          chk_go <= 1'b1;
          st     <= ST_SEEK_CHK;
        end
        ST_SEEK_CHK: if (res_vld) begin
          sh_go     <= 1'b1;
          sh_dir_go <= 1'b1;
          st        <= res_pass ? ST_MEAS_SH : ST_SEEK_SH;
        end
        ST_SEEK_SH: if (sh_fin) begin
          if (seek_q > CNT_W'(MAX_SEEK)) begin
            done    <= 1'b1;
            success <= 1'b0;
            st      <= ST_IDLE;
          end else begin
            chk_go <= 1'b1;
            st     <= ST_SEEK_CHK;
          end
        end
        ST_MEAS_SH: if (sh_fin) begin
          chk_go <= 1'b1;
          st     <= ST_MEAS_CHK;
        end
        ST_MEAS_CHK: if (res_vld) begin
          if (res_pass) begin
            sh_go     <= 1'b1;
            sh_dir_go <= 1'b1;
            st        <= ST_MEAS_SH;
          end else if (half_w == '0) begin
            done    <= 1'b1;
            success <= 1'b1;
            st      <= ST_IDLE;
          end else begin
            bk        <= half_w;
            sh_go     <= 1'b1;
            sh_dir_go <= 1'b0;
            st        <= ST_BACK_SH;
          end
        end
        ST_BACK_SH: if (sh_fin) begin
          if (bk == HALF_W'(1)) begin
            done    <= 1'b1;
            success <= 1'b1;
            st      <= ST_IDLE;
          end else begin
            bk        <= bk - 1'b1;
            sh_go     <= 1'b1;
            sh_dir_go <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phalign_checks.sv
module phalign_checks (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic shift_ack,
  input logic shift_req,
  input logic shift_dir,
  input logic active,
  input logic done,
  input logic success
);
  logic outst;

  always_ff @(posedge clk) begin
    if (!rst_n)                      outst <= 1'b0;
    else if (shift_req && !shift_ack) outst <= 1'b1;
    else if (shift_ack)              outst <= 1'b0;
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_req |=> !shift_req);  // R7
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (outst && !shift_ack) |-> !shift_req);  // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active);  // R9
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(active));  // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> $stable(success));  // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !shift_req);  // R10
endmodule

bind phase_eye_centerer phalign_checks u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .shift_ack(shift_ack),
  .shift_req(shift_req),
  .shift_dir(shift_dir),
  .active   (active),
  .done     (done),
  .success  (success)
);

// File: tb/sim_phase_eye_centerer.sv
module sim_phase_eye_centerer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [6:0] sample = 7'd0;
  logic       shift_ack = 1'b0;
  logic       shift_req, shift_dir, active, done, success;

  always #10 clk = ~clk;

  phase_eye_centerer u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .sample(sample),
    .shift_ack(shift_ack), .shift_req(shift_req), .shift_dir(shift_dir),
    .active(active), .done(done), .success(success)
  );

  localparam logic [6:0] MATCH = 7'b1100011;
  localparam logic [6:0] JITTER = 7'b1110011;

  typedef struct {
    bit ok;
    int pos;
    int fwd;
    int back;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int total = 0, bad = 0;
  int e_per, e_lo, e_len, f_lo, f_hi;
  logic [6:0] miss_word;
  int pos, fwd_n, back_n, gcnt, ack_cd;
  logic pend_dir;
  int viol_r7 = 0, viol_r8 = 0, viol_r9 = 0;
  logic prev_req = 1'b0, prev_done = 1'b0;

  task automatic chk(input bit cond, input string req, input int act, input int expv);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int wrapm(input int p);
    return ((p % e_per) + e_per) % e_per;
  endfunction

  function automatic bit in_win(input int p);
    int m = wrapm(p);
    return (m >= e_lo) && (m < e_lo + e_len);
  endfunction

  function automatic bit jittery(input int p);
    int m = wrapm(p);
    return (m >= f_lo) && (m < f_hi);
  endfunction

  function automatic bit good(input int p);
    return in_win(p) && !jittery(p);
  endfunction

  function automatic logic [6:0] word_at(input int p, input int g);
    if (!in_win(p)) return miss_word;
    if (jittery(p) && (g % 32 == 0)) return JITTER;
    return MATCH;
  endfunction

  // shifter and eye model
  always @(negedge clk) begin
    gcnt++;
    shift_ack = 1'b0;
    if (ack_cd > 0) begin
      ack_cd--;
      if (ack_cd == 0) begin
        shift_ack = 1'b1;
        if (pend_dir) begin pos++; fwd_n++; end
        else begin pos--; back_n++; end
      end
    end
    if (shift_req) begin
      if (ack_cd > 0) viol_r8++;
      if (prev_req) viol_r7++;
      pend_dir = shift_dir;
      ack_cd = 2;
    end
    prev_req = shift_req;
    sample = word_at(pos, gcnt);
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (done && prev_done) viol_r9++;
    prev_done = done;
    if (done) begin
      exp_t e;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected done", 1, 0);
      end else begin
        e = exp_q.pop_front();
        chk(success == e.ok, {e.tag, " success"}, int'(success), int'(e.ok));
        chk(active == 1'b0, "R9 active low with done", int'(active), 0);
        chk(fwd_n == e.fwd, {e.tag, " R7 forward steps"}, fwd_n, e.fwd);
        chk(back_n == e.back, {e.tag, " R6 backward steps"}, back_n, e.back);
        if (e.ok) chk(pos == e.pos, {e.tag, " final phase"}, pos, e.pos);
      end
    end
  end

  task automatic run_case(input string tag, input int per, input int lo, input int len,
                          input int flo, input int fhi, input logic [6:0] mw, input int sp);
    exp_t e;
    int p, cnt, w, nf;
    e_per = per; e_lo = lo; e_len = len; f_lo = flo; f_hi = fhi; miss_word = mw;
    pos = sp; fwd_n = 0; back_n = 0;
    p = sp; nf = 0;
    while (good(p) && nf < 100000) begin p++; nf++; end
    p++; nf++;
    cnt = 0; e.ok = 1'b1;
    while (!good(p)) begin
      p++; nf++; cnt++;
      if (cnt > 1024) begin e.ok = 1'b0; break; end
    end
    e.back = 0;
    if (e.ok) begin
      w = 1; p++; nf++;
      while (good(p)) begin p++; nf++; w++; end
      e.back = w / 2;
      p -= e.back;
    end
    e.pos = p; e.fwd = nf; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 60000; i++) begin
      if (exp_q.size() == 0) break;
      @(negedge clk);
    end
    chk(exp_q.size() == 0, {tag, " run finished"}, exp_q.size(), 0);
    exp_q.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    gcnt = 0; ack_cd = 0; pend_dir = 1'b0; pos = 0; fwd_n = 0; back_n = 0;
    e_per = 40; e_lo = 0; e_len = 0; f_lo = 0; f_hi = 0; miss_word = 7'd0;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(active == 1'b0, "R10 active", int'(active), 0);
    chk(done == 1'b0, "R10 done", int'(done), 0);
    chk(success == 1'b0, "R10 success", int'(success), 0);
    chk(shift_req == 1'b0, "R10 shift_req", int'(shift_req), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(shift_req == 1'b0 && active == 1'b0, "R10 idle quiet", int'(shift_req), 0);
    // R3 R5 R6: start inside an odd-width window
    run_case("R3 R5 R6 inside", 40, 10, 9, 0, 0, 7'd0, 12);
    // R3 R4: start outside the window
    run_case("R3 R4 outside", 40, 10, 9, 0, 0, 7'd0, 0);
    // R6 even width
    run_case("R6 even", 40, 10, 8, 0, 0, 7'b0011100, 30);
    // R6 width one: no backward step
    run_case("R6 width1", 40, 20, 1, 0, 0, 7'd0, 5);
    // R2 jittery positions split the window
    run_case("R2 jitter", 40, 5, 14, 9, 11, 7'd0, 0);
    // R1 near-miss word counts as miss
    run_case("R1 nearmiss", 40, 3, 5, 0, 0, 7'b1100010, 0);
    // R4 window after exactly 1024 search steps
    run_case("R4 bound ok", 2000, 1025, 3, 0, 0, 7'd0, 0);
    // R4 one step further: failure
    run_case("R4 bound fail", 2000, 1026, 3, 0, 0, 7'd0, 0);
    // R4 never any window
    run_case("R4 no window", 40, 0, 0, 0, 0, 7'd0, 0);
    // R9 result held while idle
    repeat (20) @(negedge clk);
    chk(success == 1'b0 && done == 1'b0, "R9 held", int'(success), 0);
    chk(viol_r7 == 0, "R7 request pulse width", viol_r7, 0);
    chk(viol_r8 == 0, "R8 request while outstanding", viol_r8, 0);
    chk(viol_r9 == 0, "R9 done pulse width", viol_r9, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule